// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits at the head of a MAC receive path and decides, from the 48-bit destination address of each incoming frame, whether the frame is kept. The destination bytes arrive one per valid cycle, the first marked by a start strobe. One cycle after the sixth byte the block raises a one-cycle decision strobe together with an accept flag. The accept flag is set when any enabled rule matches. The rules are three perfect-match address slots, a broadcast rule, a promiscuous rule and a 64-bin multicast hash.

The host sets the block up through three write ports. A 3-bit pointer selects a target: value 0 is the station's own address slot, values 2 and 3 are two extra address slots, and value 7 is the hash table. An indexed byte window writes into the selected target. A control word holds one enable per rule. The whole configuration is copied into a per-frame snapshot when a frame's first byte arrives. A frame that is already being collected therefore keeps the rules it started with.

A small state machine steers the frame. S_IDLE waits for a start byte and moves to S_GATHER when one arrives. S_GATHER counts the destination bytes. Another start byte restarts the count and keeps the machine in S_GATHER. The sixth byte moves it to S_ISSUE. S_ISSUE drives the decision strobe for one cycle. It then returns to S_IDLE, or goes to S_GATHER if a new start byte arrives in that same cycle.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset dec_vld and dec_accept are 0, every address slot and hash bit is 0 and every enable is off, so every frame is rejected.
- R2: dec_vld is a one-cycle pulse in the cycle after the sixth destination byte. A byte counts when rx_vld is 1, and the count includes the start byte, marked by rx_vld and rx_sof both 1. Idle cycles inside the address do not count. A new start byte restarts collection. Bytes outside a frame's first six are ignored. dec_accept is 0 whenever dec_vld is 0.
- R3: With cfg_ptr_wdata 0, 2 or 3 written to the pointer, window byte i (0 to 5) holds received byte i of that slot's address. A destination equal to the slot is accepted when the slot's enable is set: control bit 0 for slot 0, bit 1 for slot 2, bit 2 for slot 3.
- R4: A destination equal to a slot whose enable bit is clear is not accepted through that slot.
- R5: With control bit 3 set, the all-ones destination is accepted. Any other address is not accepted by this rule.
- R6: With control bit 5 set, every frame is accepted.
- R7: With control bit 4 set, a multicast destination other than broadcast is accepted when its hash bit is set. An address is multicast when bit 0 of its first received byte is 1. The hash bin is bits 31..26 of a CRC-32 over the six bytes in arrival order. The CRC register starts at all ones, takes each byte LSB first with the reflected polynomial 0xEDB88320, and has no final inversion. Broadcast is never accepted through the hash.
- R8: A unicast destination is never accepted through the hash, even with all 64 hash bits set.
- R9: With the pointer at 7, window byte k (0 to 7) writes hash bins 8k to 8k+7, with bin 8k at bit 0. Window writes while the pointer is 1, 4, 5 or 6 are ignored. Window bytes 6 and 7 are ignored for slot pointers.
- R10: A control write in the cycle of a frame's start byte, or later, does not affect that frame. It applies to the next frame.
- R11: When several rules are enabled, a frame is accepted if any one of them matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ptr_we | input | 1 | Write strobe for the target pointer |
| cfg_ptr_wdata | input | 3 | Pointer value: 0, 2, 3 address slots, 7 hash table |
| cfg_win_we | input | 1 | Write strobe for one byte of the window |
| cfg_win_idx | input | WIN_IDX_W (3) | Byte index inside the selected target |
| cfg_win_wdata | input | 8 | Byte written through the window |
| cfg_ctrl_we | input | 1 | Write strobe for the control word |
| cfg_ctrl_wdata | input | 6 | Enables: b0 slot 0, b1 slot 2, b2 slot 3, b3 broadcast, b4 hash, b5 promiscuous |
| rx_vld | input | 1 | A destination byte is present |
| rx_sof | input | 1 | Marks the first destination byte (with rx_vld) |
| rx_data | input | 8 | Destination byte |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted (meaningful with dec_vld) |

## Verification
The bench builds the block with the default HASH_BITS of 64. At this size the window index is 3 bits wide and the full table is reachable as eight window bytes. The bin is a 6-bit slice of the CRC. So the bench can clear the table, set the single bin of one multicast address that it computes itself, and check that only that bin opens the hash path. The same width lets the bench set all 64 bits and confirm that unicast and broadcast still bypass the hash.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int NSLOT      = 3;
    localparam int PTR_W      = 3;
    localparam int CTRL_W     = 6;

    // control word bit positions; slot s is enabled by bit s
    localparam int CB_BCAST = 3;
    localparam int CB_MHASH = 4;
    localparam int CB_PROM  = 5;

    // pointer value that reaches each perfect-match slot
    localparam int SLOT_PTR [NSLOT] = '{0, 2, 3};
    localparam logic [PTR_W-1:0] PTR_HASH = 3'd7;

    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_GATHER = 2'd1,
        S_ISSUE  = 2'd2
    } flt_state_t;

    // one byte of reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc_step(input logic [31:0] cin,
                                             input logic [7:0]  din);
        logic [31:0] c;
        c = cin;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ CRC_POLY;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 64,
    parameter int WIN_IDX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ptr_we,
    input  logic [PTR_W-1:0]          ptr_wd,
    input  logic                      win_we,
    input  logic [WIN_IDX_W-1:0]      win_idx,
    input  logic [7:0]                win_wd,
    input  logic                      ctrl_we,
    input  logic [CTRL_W-1:0]         ctrl_wd,
    output logic [CTRL_W-1:0]         ctrl_q,
    output logic [NSLOT*ADDR_W-1:0]   slot_flat,
    output logic [HASH_BITS-1:0]      hash_q
);

    localparam int HASH_BYTES = HASH_BITS / 8;

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (ptr_we) ptr_q <= ptr_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wd;
    end

    // perfect-match slots: byte b of the window is received byte b
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [ADDR_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (win_we && ptr_q == PTR_W'(SLOT_PTR[s])) begin
                for (int b = 0; b < ADDR_BYTES; b++) begin
                    if (int'(win_idx) == b)
                        val_q[(ADDR_BYTES-1-b)*8 +: 8] <= win_wd;
                end
            end
        end
        assign slot_flat[s*ADDR_W +: ADDR_W] = val_q;
    end

    // hash table: window byte k carries bins 8k..8k+7
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hash_q <= '0;
        end else if (win_we && ptr_q == PTR_HASH) begin
            for (int k = 0; k < HASH_BYTES; k++) begin
                if (int'(win_idx) == k)
                    hash_q[k*8 +: 8] <= win_wd;
            end
        end
    end

    // R9: a window write through an unmapped pointer changes no storage
    a_r9_dead_ptr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && (ptr_q inside {3'd1, 3'd4, 3'd5, 3'd6}))
        |=> ($stable(slot_flat) && $stable(hash_q)));

endmodule

// File: rtl/rxf_crc_unit.sv
module rxf_crc_unit
    import rxf_pkg::*;
#(
    parameter int BIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [7:0]       din,
    output logic [BIN_W-1:0] bin_next
);

    logic [31:0] crc_q;
    logic [31:0] crc_next;

    always_comb begin
        crc_next = crc_step(restart ? CRC_SEED : crc_q, din);
        bin_next = crc_next[31 -: BIN_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= CRC_SEED;
        else if (step) crc_q <= crc_next;
    end

endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 64,
    parameter int BIN_W     = 6
) (
    input  logic [CTRL_W-1:0]       ctrl,
    input  logic [NSLOT*ADDR_W-1:0] slot_flat,
    input  logic [HASH_BITS-1:0]    hash,
    input  logic [ADDR_W-1:0]       dest,
    input  logic [BIN_W-1:0]        bin,
    output logic                    accept
);

    logic [NSLOT-1:0] slot_hit;
    logic             is_bcast;
    logic             is_mcast;
    logic             hash_hit;

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        assign slot_hit[s] = ctrl[s] && (slot_flat[s*ADDR_W +: ADDR_W] == dest);
    end

    always_comb begin
        is_bcast = &dest;
        is_mcast = dest[ADDR_W-8];   // bit 0 of the first received byte
        hash_hit = ctrl[CB_MHASH] && is_mcast && !is_bcast && hash[bin];
        accept   = ctrl[CB_PROM]
                 | (ctrl[CB_BCAST] & is_bcast)
                 | (|slot_hit)
                 | hash_hit;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter  int HASH_BITS  = 64,
    localparam int HASH_BYTES = HASH_BITS / 8,
    localparam int WIN_IDX_W  = $clog2(HASH_BYTES > ADDR_BYTES ? HASH_BYTES : ADDR_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_ptr_we,
    input  logic [PTR_W-1:0]     cfg_ptr_wdata,
    input  logic                 cfg_win_we,
    input  logic [WIN_IDX_W-1:0] cfg_win_idx,
    input  logic [7:0]           cfg_win_wdata,
    input  logic                 cfg_ctrl_we,
    input  logic [CTRL_W-1:0]    cfg_ctrl_wdata,
    input  logic                 rx_vld,
    input  logic                 rx_sof,
    input  logic [7:0]           rx_data,
    output logic                 dec_vld,
    output logic                 dec_accept
);

    localparam int BIN_W = $clog2(HASH_BITS);
    localparam int CNT_W = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    flt_state_t state_q, state_d;

    logic [CNT_W-1:0]          cnt_q;
    logic [ADDR_W-9:0]         addr_q;
    logic [ADDR_W-1:0]         dest;
    logic                      byte_sof, in_frame_byte, last_byte;
    logic [BIN_W-1:0]          bin_next;
    logic                      match_acc;
    logic                      dec_accept_q;

    logic [CTRL_W-1:0]         cfg_ctrl;
    logic [NSLOT*ADDR_W-1:0]   cfg_slots;
    logic [HASH_BITS-1:0]      cfg_hash;
    logic [CTRL_W-1:0]         act_ctrl;
    logic [NSLOT*ADDR_W-1:0]   act_slots;
    logic [HASH_BITS-1:0]      act_hash;

    rxf_cfg_regs #(.HASH_BITS(HASH_BITS), .WIN_IDX_W(WIN_IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_we    (cfg_ptr_we),
        .ptr_wd    (cfg_ptr_wdata),
        .win_we    (cfg_win_we),
        .win_idx   (cfg_win_idx),
        .win_wd    (cfg_win_wdata),
        .ctrl_we   (cfg_ctrl_we),
        .ctrl_wd   (cfg_ctrl_wdata),
        .ctrl_q    (cfg_ctrl),
        .slot_flat (cfg_slots),
        .hash_q    (cfg_hash)
    );

    always_comb begin
        byte_sof      = rx_vld && rx_sof;
        in_frame_byte = rx_vld && !rx_sof && (state_q == S_GATHER);
        last_byte     = in_frame_byte && (cnt_q == LAST);
        dest          = {addr_q, rx_data};
    end

    rxf_crc_unit #(.BIN_W(BIN_W)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (byte_sof || in_frame_byte),
        .restart  (byte_sof),
        .din      (rx_data),
        .bin_next (bin_next)
    );

    rxf_match #(.HASH_BITS(HASH_BITS), .BIN_W(BIN_W)) u_match (
        .ctrl      (act_ctrl),
        .slot_flat (act_slots),
        .hash      (act_hash),
        .dest      (dest),
        .bin       (bin_next),
        .accept    (match_acc)
    );

    // per-frame snapshot of the configuration, taken at the start byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ctrl  <= '0;
            act_slots <= '0;
            act_hash  <= '0;
        end else if (byte_sof) begin
            act_ctrl  <= cfg_ctrl;
            act_slots <= cfg_slots;
            act_hash  <= cfg_hash;
        end
    end

    // destination byte collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (byte_sof) begin
            cnt_q  <= CNT_W'(1);
            addr_q <= {{(ADDR_W-16){1'b0}}, rx_data};
        end else if (in_frame_byte) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            addr_q <= {addr_q[ADDR_W-17:0], rx_data};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (byte_sof) state_d = S_GATHER;
            S_GATHER: begin
                if (byte_sof)       state_d = S_GATHER;
                else if (last_byte) state_d = S_ISSUE;
            end
            S_ISSUE:  state_d = byte_sof ? S_GATHER : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_accept_q <= 1'b0;
        else        dec_accept_q <= last_byte && match_acc;
    end

    always_comb begin
        dec_vld    = (state_q == S_ISSUE);
        dec_accept = dec_accept_q;
    end

    // R2: the sixth byte of a frame yields a decision strobe one cycle later
    a_r2_issue_after_sixth: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> dec_vld);

    // R2: the decision strobe never lasts two cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    // R6: a frame whose snapshot has promiscuous set is accepted
    a_r6_prom_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && act_ctrl[CB_PROM]) |=> dec_accept);

    // R10: the snapshot holds while a frame is being collected
    a_r10_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_GATHER) && !byte_sof)
        |=> ($stable(act_ctrl) && $stable(act_slots) && $stable(act_hash)));

    // R1: with every rule disabled the decision is reject
    a_r1_no_rule_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && act_ctrl == '0) |-> !dec_accept);

    // R2: accept is never raised without the strobe
    a_r2_accept_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_vld);

endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ptr_we = 1'b0;
    logic [2:0] cfg_ptr_wdata = '0;
    logic       cfg_win_we = 1'b0;
    logic [2:0] cfg_win_idx = '0;
    logic [7:0] cfg_win_wdata = '0;
    logic       cfg_ctrl_we = 1'b0;
    logic [5:0] cfg_ctrl_wdata = '0;
    logic       rx_vld = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_data = '0;
    logic       dec_vld;
    logic       dec_accept;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    rx_addr_filter dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_ptr_we(cfg_ptr_we), .cfg_ptr_wdata(cfg_ptr_wdata),
        .cfg_win_we(cfg_win_we), .cfg_win_idx(cfg_win_idx), .cfg_win_wdata(cfg_win_wdata),
        .cfg_ctrl_we(cfg_ctrl_we), .cfg_ctrl_wdata(cfg_ctrl_wdata),
        .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_data(rx_data),
        .dec_vld(dec_vld), .dec_accept(dec_accept)
    );

    localparam logic [47:0] A_OWN = 48'h02_11_22_33_44_55;
    localparam logic [47:0] A_X2  = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] A_X3  = 48'h0A_0B_0C_0D_0E_0F;
    localparam logic [47:0] A_BC  = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] A_M1  = 48'h01_00_5E_0A_0B_0C;
    localparam logic [47:0] A_M2  = 48'h33_33_00_00_00_01;
    localparam logic [47:0] A_UNI = 48'h02_11_22_33_44_AA;

    // {control, destination, expected accept}
    localparam int NVEC = 15;
    localparam logic [54:0] VEC [NVEC] = '{
        {6'h01, A_OWN,               1'b1},
        {6'h00, A_OWN,               1'b0},
        {6'h06, A_OWN,               1'b0},
        {6'h02, A_X2,                1'b1},
        {6'h04, A_X2,                1'b0},
        {6'h04, A_X3,                1'b1},
        {6'h07, 48'h0A0B0C0D0E0E,    1'b0},
        {6'h08, A_BC,                1'b1},
        {6'h07, A_BC,                1'b0},
        {6'h08, 48'hFFFFFFFFFFFE,    1'b0},
        {6'h20, 48'h123456789ABC,    1'b1},
        {6'h20, A_BC,                1'b1},
        {6'h10, 48'h01005E7F0001,    1'b0},
        {6'h0F, 48'h020000000000,    1'b0},
        {6'h0F, A_X3,                1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_ptr(input logic [2:0] p);
        cfg_ptr_we = 1'b1; cfg_ptr_wdata = p;
        @(negedge clk);
        cfg_ptr_we = 1'b0;
    endtask

    task automatic wr_win(input logic [2:0] idx, input logic [7:0] d);
        cfg_win_we = 1'b1; cfg_win_idx = idx; cfg_win_wdata = d;
        @(negedge clk);
        cfg_win_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        cfg_ctrl_we = 1'b1; cfg_ctrl_wdata = v;
        @(negedge clk);
        cfg_ctrl_we = 1'b0;
    endtask

    task automatic wr_addr(input logic [2:0] p, input logic [47:0] a);
        wr_ptr(p);
        for (int i = 0; i < 6; i++) wr_win(3'(i), a[47-8*i -: 8]);
    endtask

    // reference hash bin: reflected CRC-32, seed all ones, no final inversion
    function automatic int ref_bin(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  b;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            b = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                if (c[0] ^ b[j]) c = (c >> 1) ^ 32'hEDB8_8320;
                else             c = c >> 1;
            end
        end
        return int'(c[31:26]);
    endfunction

    // sends six destination bytes; optional idle cycle after byte gap_at;
    // optional control write while byte wr_at is presented
    task automatic send_frame(input logic [47:0] a, input int gap_at,
                              input int wr_at, input logic [5:0] wr_val,
                              output logic got_vld, output logic got_acc,
                              output logic early);
        early = 1'b0;
        for (int i = 0; i < 6; i++) begin
            rx_vld = 1'b1; rx_sof = (i == 0); rx_data = a[47-8*i -: 8];
            cfg_ctrl_we = (i == wr_at); cfg_ctrl_wdata = wr_val;
            if (i > 0 && dec_vld) early = 1'b1;
            @(negedge clk);
            cfg_ctrl_we = 1'b0;
            if (i == gap_at) begin
                rx_vld = 1'b0; rx_sof = 1'b0;
                if (dec_vld) early = 1'b1;
                @(negedge clk);
            end
        end
        got_vld = dec_vld;
        got_acc = dec_accept;
        rx_vld = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic v, a, e;
        int   b1, b2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 dec_vld after reset", 32'(dec_vld), 0);
        check("R1 dec_accept after reset", 32'(dec_accept), 0);
        send_frame(A_BC, -1, -1, 6'h0, v, a, e);
        check("R1 decision strobe", 32'(v), 1);
        check("R1 default config rejects", 32'(a), 0);
        @(negedge clk);

        // load the three slots
        wr_addr(3'd0, A_OWN);
        wr_addr(3'd2, A_X2);
        wr_addr(3'd3, A_X3);

        // table walk: R3 R4 R5 R6 R7 R11
        for (int n = 0; n < NVEC; n++) begin
            wr_ctrl(VEC[n][54:49]);
            send_frame(VEC[n][48:1], -1, -1, 6'h0, v, a, e);
            check($sformatf("R2 strobe vector %0d", n), 32'(v), 1);
            check($sformatf("R3/R4/R5/R6/R7/R11 accept vector %0d", n), 32'(a), 32'(VEC[n][0]));
            @(negedge clk);
        end

        // R2: no strobe before the sixth byte, idle cycle inside the address
        wr_ctrl(6'h01);
        send_frame(A_OWN, 2, -1, 6'h0, v, a, e);
        check("R2 no early strobe with gap", 32'(e), 0);
        check("R2 strobe after gapped frame", 32'(v), 1);
        check("R2 gapped frame accepted", 32'(a), 1);

        // R2: payload bytes after the address are ignored
        e = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rx_vld = 1'b1; rx_sof = 1'b0; rx_data = 8'(i);
            @(negedge clk);
            if (dec_vld) e = 1'b1;
        end
        rx_vld = 1'b0;
        check("R2 payload bytes give no strobe", 32'(e), 0);

        // R2: restart, a truncated frame then a full one
        for (int i = 0; i < 3; i++) begin
            rx_vld = 1'b1; rx_sof = (i == 0); rx_data = 8'hFF;
            @(negedge clk);
        end
        send_frame(A_OWN, -1, -1, 6'h0, v, a, e);
        check("R2 restart no early strobe", 32'(e), 0);
        check("R2 restart decision accept", 32'(a), 1);
        @(negedge clk);

        // R10: write at the start-byte cycle does not affect this frame
        wr_ctrl(6'h20);
        send_frame(48'h123456789ABC, -1, 0, 6'h00, v, a, e);
        check("R10 write at start byte ignored", 32'(a), 1);
        @(negedge clk);
        send_frame(48'h123456789ABC, -1, -1, 6'h0, v, a, e);
        check("R10 write applies to next frame", 32'(a), 0);
        @(negedge clk);
        send_frame(48'h123456789ABC, -1, 3, 6'h20, v, a, e);
        check("R10 mid-frame write ignored", 32'(a), 0);
        @(negedge clk);
        send_frame(48'h123456789ABC, -1, -1, 6'h0, v, a, e);
        check("R10 mid-frame write applies next", 32'(a), 1);
        @(negedge clk);

        // R9: unmapped pointers and out-of-slot window bytes are ignored
        wr_addr(3'd4, 48'h0600DEADBEEF);
        wr_addr(3'd1, 48'h0600DEADBEEF);
        wr_ptr(3'd0);
        wr_win(3'd6, 8'hFF);
        wr_win(3'd7, 8'hFF);
        wr_ctrl(6'h11);
        send_frame(48'h0600DEADBEEF, -1, -1, 6'h0, v, a, e);
        check("R9 unmapped pointer write ignored", 32'(a), 0);
        @(negedge clk);
        send_frame(A_OWN, -1, -1, 6'h0, v, a, e);
        check("R9 slot 0 intact", 32'(a), 1);
        @(negedge clk);
        send_frame(A_M1, -1, -1, 6'h0, v, a, e);
        check("R9 hash untouched by slot writes", 32'(a), 0);
        @(negedge clk);

        // R7 R8: all hash bits set
        wr_ptr(3'd7);
        for (int k = 0; k < 8; k++) wr_win(3'(k), 8'hFF);
        wr_ctrl(6'h10);
        send_frame(A_M1, -1, -1, 6'h0, v, a, e);
        check("R7 full table accepts multicast", 32'(a), 1);
        @(negedge clk);
        send_frame(A_UNI, -1, -1, 6'h0, v, a, e);
        check("R8 unicast bypasses hash", 32'(a), 0);
        @(negedge clk);
        send_frame(A_BC, -1, -1, 6'h0, v, a, e);
        check("R7 broadcast bypasses hash", 32'(a), 0);
        @(negedge clk);

        // R7 R9: a single bin set through window byte bin/8, bit bin%8
        b1 = ref_bin(A_M1);
        b2 = ref_bin(A_M2);
        for (int k = 0; k < 8; k++)
            wr_win(3'(k), (k == b1 / 8) ? 8'(1 << (b1 % 8)) : 8'h00);
        send_frame(A_M1, -1, -1, 6'h0, v, a, e);
        check("R7 single bin accepts its address", 32'(a), 1);
        @(negedge clk);
        send_frame(A_M2, -1, -1, 6'h0, v, a, e);
        check("R7 other address follows its own bin", 32'(a), 32'(b2 == b1));
        @(negedge clk);
        wr_ctrl(6'h00);
        send_frame(A_M1, -1, -1, 6'h0, v, a, e);
        check("R7 hash enable off rejects", 32'(a), 0);
        @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule